// File: doc/BRIEF.md
# OTP Auto-Read Streaming Engine

This block streams a run of 32-bit words out of a one-time-programmable array into a small output FIFO, so software can drain them at its own pace. Software supplies a start address in 32-bit word units and a word count written as count-minus-one, then pulses a start strobe. Each physical array word carries 64 data bits. The engine reads a physical word once and pushes whichever of its two 32-bit halves the running address asks for, lower half first.

While a run is in progress, the engine reports the live address and the live number of words still to go, and it drops its ready flag. The FIFO level is exposed so software can check for data before it pops. A popped word is also kept in a read-back register. A flush strobe empties the FIFO. If the array reports a double error on any fetch, a sticky error flag is raised and stays set until software writes one to clear it.

Top module: `otp_stream_reader`

## Requirements
- R1: Logical address bit 0 selects the half of the physical word: 0 returns bits [31:0], 1 returns bits [63:32]. Logical bits [14:1] drive `arr_addr`.
- R2: After a start, exactly `cfg_count_m1`+1 words are pushed into the FIFO at ascending logical addresses beginning at `cfg_start_addr`, and they are popped in that same order.
- R3: `live_addr` and `live_remain` are loaded on an accepted start and then step by +1 and -1 for each pushed word. At the end of a run `live_remain` is 0. While idle they hold their value even if the configuration inputs change. Both reset to 0.
- R4: `ready` is 1 after reset. It is 0 from the cycle after an accepted start until the last word has been pushed. A start pulse while `ready` is 0 is ignored.
- R5: `fifo_level` counts the stored words, from 0 up to 8 entries. A `flush` pulse makes it 0 on the next cycle.
- R6: A pop while the FIFO is empty is ignored. The level stays 0 and `rd_back` is unchanged.
- R7: An `arr_dbl_err` returned with fetched data sets `rd_err`. The flag stays set through later clean runs and clears only on a cycle with `err_clr`=1. A new error in that same cycle wins.
- R8: Each physical word is fetched at most once per run (one `arr_req` pulse per physical word touched). No fetch is issued while the FIFO is full, so a run with more words than free entries stalls with the FIFO at 8 entries until space appears.
- R9: `pop_data` shows the FIFO head. A pop copies the head into `rd_back` on the same clock edge that removes it.
- R10: After reset the FIFO is empty, `ready`=1, `rd_err`=0 and `arr_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_addr | input | 15 | Start address in 32-bit word units |
| cfg_count_m1 | input | 14 | Number of words to stream, minus one |
| start | input | 1 | Start strobe, accepted only when ready |
| flush | input | 1 | Empties the FIFO |
| pop | input | 1 | Removes the FIFO head |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| pop_data | output | 32 | Current FIFO head |
| rd_back | output | 32 | Value taken by the latest pop |
| fifo_level | output | 4 | Number of words in the FIFO |
| live_addr | output | 15 | Running logical address |
| live_remain | output | 15 | Words still to be pushed |
| ready | output | 1 | 1 when no run is in progress |
| rd_err | output | 1 | Sticky double-error flag |
| arr_req | output | 1 | Array read request; data returns one cycle later |
| arr_addr | output | 14 | Physical word address |
| arr_rdata | input | 64 | Physical word data |
| arr_dbl_err | input | 1 | Double error on the returned data |

## Verification
The bench starts runs at both even and odd addresses. A design that mixes up the half select, or that fetches the same physical word twice, shows wrong data or too many requests. A ten-word run against the eight-entry FIFO checks that the engine stalls at full and finishes after pops. A design that overflows loses words or shows a level above 8. A start pulse given mid-run must not move the live address. An error must survive a clean later run and then clear on command. Empty pops and a flush confirm that the level and the read-back register move only when they should.

// File: rtl/otp_stream_pkg.sv
package otp_stream_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PUSH  = 2'd3
  } eng_state_t;
endpackage

// File: rtl/otp_word_fifo.sv
module otp_word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    store [DEPTH];
  logic [PW-1:0]    wp_q, wp_n, rp_q, rp_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = store[rp_q];
  assign level   = lvl_q;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    lvl_n = lvl_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      lvl_n = '0;
    end else begin
      if (do_push) wp_n = bump(wp_q);
      if (do_pop)  rp_n = bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   lvl_n = lvl_q + LVL_W'(1);
        2'b01:   lvl_n = lvl_q - LVL_W'(1);
        default: lvl_n = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      lvl_q <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wp_q] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lvl_q == '0)); // R5
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (lvl_q == '0)); // R6
endmodule

// File: rtl/otp_fetch_ctrl.sv
module otp_fetch_ctrl
  import otp_stream_pkg::*;
#(
  parameter int AW = 15,
  parameter int CW = 14,
  parameter int DW = 32,
  parameter int PW = AW - 1,
  parameter int RW = CW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CW-1:0]   cfg_cnt_m1,
  input  logic            fifo_full,
  input  logic [2*DW-1:0] arr_rdata,
  input  logic            arr_dbl_err,
  output logic            arr_req,
  output logic [PW-1:0]   arr_addr,
  output logic            push,
  output logic [DW-1:0]   push_data,
  output logic            err_set,
  output logic [AW-1:0]   live_addr,
  output logic [RW-1:0]   live_remain,
  output logic            ready
);
  eng_state_t      st_q, st_n;
  logic [2*DW-1:0] word_q, word_n;
  logic [AW-1:0]   addr_q, addr_n;
  logic [RW-1:0]   rem_q, rem_n;

  assign arr_addr    = addr_q[AW-1:1];
  assign push_data   = addr_q[0] ? word_q[2*DW-1:DW] : word_q[DW-1:0];
  assign live_addr   = addr_q;
  assign live_remain = rem_q;
  assign ready       = (st_q == ST_IDLE);

  always_comb begin
    st_n    = st_q;
    word_n  = word_q;
    addr_n  = addr_q;
    rem_n   = rem_q;
    arr_req = 1'b0;
    push    = 1'b0;
    err_set = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          addr_n = cfg_addr;
          rem_n  = RW'(cfg_cnt_m1) + RW'(1);
          st_n   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (!fifo_full) begin
          arr_req = 1'b1;
          st_n    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        word_n  = arr_rdata;
        err_set = arr_dbl_err;
        st_n    = ST_PUSH;
      end
      ST_PUSH: begin
        if (!fifo_full) begin
          push   = 1'b1;
          addr_n = addr_q + AW'(1);
          rem_n  = rem_q - RW'(1);
          if (rem_q == RW'(1)) st_n = ST_IDLE;
          else if (addr_q[0])  st_n = ST_FETCH;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      rem_q  <= rem_n;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_WAIT) word_q <= word_n;
  end

  AST_ONE_REQ_PER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |=> !arr_req); // R8
  AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (live_remain == $past(live_remain) - RW'(1))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ($stable(live_addr) && $stable(live_remain))); // R3
  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (push && live_remain == RW'(1)) |=> ready); // R4
endmodule

// File: rtl/otp_err_sticky.sv
module otp_err_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_n;

  assign flag   = flag_q;
  assign flag_n = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_n;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R7
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q); // R7
endmodule

// File: rtl/otp_stream_reader.sv
module otp_stream_reader #(
  parameter int AW         = 15,
  parameter int CW         = 14,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cfg_start_addr,
  input  logic [CW-1:0]    cfg_count_m1,
  input  logic             start,
  input  logic             flush,
  input  logic             pop,
  input  logic             err_clr,
  output logic [DW-1:0]    pop_data,
  output logic [DW-1:0]    rd_back,
  output logic [LVL_W-1:0] fifo_level,
  output logic [AW-1:0]    live_addr,
  output logic [CW:0]      live_remain,
  output logic             ready,
  output logic             rd_err,
  output logic             arr_req,
  output logic [AW-2:0]    arr_addr,
  input  logic [2*DW-1:0]  arr_rdata,
  input  logic             arr_dbl_err
);
  logic          fifo_full, fifo_empty, eng_push, err_set;
  logic [DW-1:0] eng_data;
  logic [DW-1:0] back_q, back_n;
  logic          take;

  otp_fetch_ctrl #(.AW(AW), .CW(CW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_start_addr),
    .cfg_cnt_m1(cfg_count_m1), .fifo_full(fifo_full), .arr_rdata(arr_rdata),
    .arr_dbl_err(arr_dbl_err), .arr_req(arr_req), .arr_addr(arr_addr),
    .push(eng_push), .push_data(eng_data), .err_set(err_set),
    .live_addr(live_addr), .live_remain(live_remain), .ready(ready)
  );

  otp_word_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(eng_push),
    .push_data(eng_data), .pop(pop), .head(pop_data), .level(fifo_level),
    .full(fifo_full), .empty(fifo_empty)
  );

  otp_err_sticky u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .flag(rd_err)
  );

  assign take    = pop && !fifo_empty && !flush;
  assign back_n  = take ? pop_data : back_q;
  assign rd_back = back_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) back_q <= '0;
    else        back_q <= back_n;
  end

  AST_BACK_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fifo_empty) |=> $stable(rd_back)); // R6
endmodule

// File: tb/tb_otp_stream_reader.sv
`timescale 1ns/1ps
module tb_otp_stream_reader;
  logic        clk, rst_n;
  logic [14:0] cfg_start_addr;
  logic [13:0] cfg_count_m1;
  logic        start, flush, pop, err_clr;
  logic [31:0] pop_data, rd_back;
  logic [3:0]  fifo_level;
  logic [14:0] live_addr;
  logic [14:0] live_remain;
  logic        ready, rd_err, arr_req;
  logic [13:0] arr_addr;
  logic [63:0] arr_rdata;
  logic        arr_dbl_err;

  int checks = 0;
  int errors = 0;
  int fetches = 0;

  otp_stream_reader dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] word32(input logic [14:0] l);
    return {8'h5A, 9'h0, l};
  endfunction

  // Array model: data and error one cycle after the request.
  always @(posedge clk) begin
    if (arr_req) begin
      arr_rdata   <= {word32({arr_addr, 1'b1}), word32({arr_addr, 1'b0})};
      arr_dbl_err <= (arr_addr == 14'd50);
      fetches     <= fetches + 1;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [14:0] a, input logic [13:0] n);
    cfg_start_addr = a; cfg_count_m1 = n; start = 1'b1;
    tick(); start = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200 && !ready; i++) tick();
  endtask

  task automatic pop_chk(input string req, input logic [31:0] exp);
    chk(req, pop_data, exp);
    pop = 1'b1; tick(); pop = 1'b0;
    chk("R9 rd_back", rd_back, exp);
  endtask

  task automatic t_reset();
    chk("R10 level", 32'(fifo_level), 0);
    chk("R10 ready", 32'(ready), 1);
    chk("R10 rd_err", 32'(rd_err), 0);
    chk("R10 arr_req", 32'(arr_req), 0);
    chk("R3 reset live_addr", 32'(live_addr), 0);
  endtask

  task automatic t_even();
    int f0 = fetches;
    kick(15'd4, 14'd3);
    chk("R4 busy after start", 32'(ready), 0);
    wait_ready();
    chk("R2 level 4", 32'(fifo_level), 4);
    chk("R8 two fetches", 32'(fetches - f0), 2);
    chk("R3 live_addr end", 32'(live_addr), 8);
    chk("R3 live_remain end", 32'(live_remain), 0);
    for (int i = 0; i < 4; i++) pop_chk("R1 even run data", word32(15'(4 + i)));
    cfg_start_addr = 15'd300; tick(); tick();
    chk("R3 idle hold", 32'(live_addr), 8);
  endtask

  task automatic t_odd();
    int f0 = fetches;
    kick(15'd7, 14'd1);
    wait_ready();
    chk("R8 odd fetches", 32'(fetches - f0), 2);
    pop_chk("R1 upper half first", word32(15'd7));
    pop_chk("R1 lower half next", word32(15'd8));
  endtask

  task automatic t_full();
    int f0 = fetches;
    kick(15'd0, 14'd9);
    for (int i = 0; i < 40; i++) tick();
    chk("R8 stall level", 32'(fifo_level), 8);
    chk("R4 still busy", 32'(ready), 0);
    chk("R8 stall fetches", 32'(fetches - f0), 4);
    chk("R3 stall remain", 32'(live_remain), 2);
    kick(15'd200, 14'd0);
    chk("R4 start ignored", 32'(live_addr), 8);
    pop_chk("R2 order 0", word32(15'd0));
    pop_chk("R2 order 1", word32(15'd1));
    wait_ready();
    chk("R5 level refilled", 32'(fifo_level), 8);
    for (int i = 2; i < 10; i++) pop_chk("R2 order tail", word32(15'(i)));
    chk("R8 total fetches", 32'(fetches - f0), 5);
  endtask

  task automatic t_empty_pop();
    logic [31:0] prev = rd_back;
    pop = 1'b1; tick(); pop = 1'b0;
    chk("R6 level stays 0", 32'(fifo_level), 0);
    chk("R6 rd_back unchanged", rd_back, prev);
  endtask

  task automatic t_flush();
    kick(15'd20, 14'd2);
    wait_ready();
    chk("R5 level 3", 32'(fifo_level), 3);
    flush = 1'b1; tick(); flush = 1'b0;
    chk("R5 flushed", 32'(fifo_level), 0);
  endtask

  task automatic t_err();
    kick(15'd100, 14'd0);
    wait_ready(); tick();
    chk("R7 set", 32'(rd_err), 1);
    flush = 1'b1; tick(); flush = 1'b0;
    kick(15'd10, 14'd1);
    wait_ready(); tick();
    chk("R7 sticky", 32'(rd_err), 1);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk("R7 cleared", 32'(rd_err), 0);
    flush = 1'b1; tick(); flush = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; flush = 1'b0; pop = 1'b0; err_clr = 1'b0;
    cfg_start_addr = '0; cfg_count_m1 = '0;
    arr_rdata = '0; arr_dbl_err = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_even();
    t_odd();
    t_full();
    t_empty_pop();
    t_flush();
    t_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule